// File: doc/BRIEF.md
# Prioritised Interrupt Pending Selector

This block decides, every cycle, whether a hart should take an interrupt and which one. It takes flat vectors of pending requests, per-source enables and a per-source delegation mask. Each source is routed to either machine level (not delegated) or supervisor level (delegated). It also takes the current privilege level and the two global enable bits, one for machine level and one for supervisor level. A source is eligible when it is both pending and enabled, and when the level it is routed to is currently open to interrupts.

Among all eligible sources the lowest-numbered one wins. The block reports a take flag and the winning index. When no source is eligible, the flag is low and the index reads zero. By default the outputs are registered, so they reflect the inputs one clock later. A parameter removes the register and makes the path purely combinational.

Top module: `irq_select_top`

## Requirements
- R1: A source can only be chosen when its bit is set in both `pend_i` and `en_i`; a pending source whose enable is clear is never reported.
- R2: A non-delegated source (`deleg_i` bit 0) is open when the privilege is below machine, or when it is machine and `m_gie_i` is 1; at machine privilege with `m_gie_i` 0 none of them is taken.
- R3: A delegated source (`deleg_i` bit 1) is open when the privilege is user, or when it is supervisor and `s_gie_i` is 1; at machine privilege a delegated source is never taken, whatever `s_gie_i` is.
- R4: The eligible set is the union of the open non-delegated candidates and the open delegated candidates, so both kinds compete in one priority order.
- R5: When several sources are eligible, the one with the lowest bit number wins and its number is driven on `cause_o`.
- R6: When no source is eligible, `take_o` is 0 and `cause_o` is 0.
- R7: Privilege encoding on `priv_i`: 0 user, 1 supervisor, 3 machine; the value 2 is handled exactly like user.
- R8: With the default `REG_OUT`=1, `take_o` and `cause_o` show the result for the inputs present at the previous rising clock edge; while `rst_n` is low at a rising edge, both are cleared to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge samples the result |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| pend_i | input | NUM_IRQ | Pending request per source |
| en_i | input | NUM_IRQ | Enable per source |
| deleg_i | input | NUM_IRQ | 1 routes the source to supervisor level, 0 to machine level |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 2 as user, 3 machine) |
| m_gie_i | input | 1 | Machine-level global interrupt enable |
| s_gie_i | input | 1 | Supervisor-level global interrupt enable |
| take_o | output | 1 | An interrupt should be taken |
| cause_o | output | IDX_W | Index of the winning source, 0 when `take_o` is low |

## Verification
The hardest case is a low-numbered source that is pending and enabled but whose level is closed. An example is a delegated source while the hart runs at machine privilege. A higher-numbered non-delegated source must then win even though a plain trailing-zero search over pending and enable would return the lower bit. The bench sets this up directly: it places a delegated and a non-delegated source side by side and walks the privilege and the global enables through each combination. Random vectors then mix all three masks against a behavioural model, which is checked on every clock.

// File: rtl/irq_sel_pkg.sv
// Package: shared privilege encoding for the interrupt selector.
// Assumes a 2-bit privilege field; the reserved code is folded into user.
package irq_sel_pkg;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

endpackage

// File: rtl/irq_gate.sv
// Module: irq_gate
// Computes the eligible-source vector from the pending, enable and delegation
// masks, gated by whether the machine or supervisor level is open at the
// current privilege. Purely combinational; clk/rst_n serve the assertions only.
module irq_gate
    import irq_sel_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] pend_i,
    input  logic [NUM_IRQ-1:0] en_i,
    input  logic [NUM_IRQ-1:0] deleg_i,
    input  logic [1:0]         priv_i,
    input  logic               m_gie_i,
    input  logic               s_gie_i,
    output logic [NUM_IRQ-1:0] elig_o
);

    priv_e              lvl;
    logic               mach_open;
    logic               sup_open;
    logic [NUM_IRQ-1:0] cand;

    assign lvl = priv_e'(priv_i);

    // Decide which levels accept interrupts at the current privilege (R2, R3, R7)
    always_comb begin
        mach_open = (lvl != PRIV_MACH) || m_gie_i;
        unique case (lvl)
            PRIV_USER, PRIV_RSVD: sup_open = 1'b1;
            PRIV_SUPER:           sup_open = s_gie_i;
            default:              sup_open = 1'b0;
        endcase
    end

    // Mask candidates by routing and open level, then merge both routes (R1, R4)
    always_comb begin
        cand   = pend_i & en_i;
        elig_o = (cand & ~deleg_i & {NUM_IRQ{mach_open}})
               | (cand &  deleg_i & {NUM_IRQ{sup_open}});
    end

    // R1
    elig_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (elig_o & ~(pend_i & en_i)) == '0);

    // R2
    mach_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_i == 2'd3 && !m_gie_i) |-> (elig_o & ~deleg_i) == '0);

    // R3
    mach_no_deleg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_i == 2'd3) |-> (elig_o & deleg_i) == '0);

endmodule

// File: rtl/irq_lowest.sv
// Module: irq_lowest
// Finds the lowest set bit of a vector: isolates it with a two's-complement
// mask, then encodes the one-hot result with one OR tree per index bit.
// Assumes NUM_IRQ is a power of two so every index value is a real source.
module irq_lowest #(
    parameter int NUM_IRQ = 32,
    localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] vec_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);

    logic [NUM_IRQ-1:0] lowest;

    // Select positions whose index has bit b set
    function automatic logic [NUM_IRQ-1:0] bit_mask(input int b);
        logic [NUM_IRQ-1:0] m;
        for (int i = 0; i < NUM_IRQ; i++) m[i] = ((i >> b) & 1) == 1;
        return m;
    endfunction

    // Keep only the lowest set bit (R5)
    assign lowest = vec_i & (~vec_i + {{(NUM_IRQ-1){1'b0}}, 1'b1});
    assign any_o  = |vec_i;

    // One reduction per index bit encodes the one-hot winner
    for (genvar b = 0; b < IDX_W; b++) begin : g_enc
        localparam logic [NUM_IRQ-1:0] SEL = bit_mask(b);
        assign idx_o[b] = |(lowest & SEL);
    end

    // R5
    winner_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> vec_i[idx_o]);

    // R5
    none_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> (vec_i & ((NUM_IRQ'(1) << idx_o) - NUM_IRQ'(1))) == '0);

endmodule

// File: rtl/irq_select_top.sv
// Module: irq_select_top
// Prioritised interrupt selector: gates candidates by routing and privilege,
// picks the lowest eligible index, and optionally registers the result.
// Assumes a synchronous active-low reset and NUM_IRQ a power of two.
module irq_select_top #(
    parameter int  NUM_IRQ = 32,
    parameter bit  REG_OUT = 1'b1,
    localparam int IDX_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] pend_i,
    input  logic [NUM_IRQ-1:0] en_i,
    input  logic [NUM_IRQ-1:0] deleg_i,
    input  logic [1:0]         priv_i,
    input  logic               m_gie_i,
    input  logic               s_gie_i,
    output logic               take_o,
    output logic [IDX_W-1:0]   cause_o
);

    logic [NUM_IRQ-1:0] elig;
    logic               any_elig;
    logic [IDX_W-1:0]   win_idx;
    logic [IDX_W-1:0]   cause_d;

    irq_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (pend_i),
        .en_i    (en_i),
        .deleg_i (deleg_i),
        .priv_i  (priv_i),
        .m_gie_i (m_gie_i),
        .s_gie_i (s_gie_i),
        .elig_o  (elig)
    );

    irq_lowest #(.NUM_IRQ(NUM_IRQ)) u_lowest (
        .clk   (clk),
        .rst_n (rst_n),
        .vec_i (elig),
        .any_o (any_elig),
        .idx_o (win_idx)
    );

    // Force the index to zero when nothing is eligible (R6)
    assign cause_d = any_elig ? win_idx : '0;

    if (REG_OUT) begin : g_reg
        logic             take_q;
        logic [IDX_W-1:0] cause_q;

        // Capture the decision on the rising edge; reset clears it (R8)
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                take_q  <= 1'b0;
                cause_q <= '0;
            end else begin
                take_q  <= any_elig;
                cause_q <= cause_d;
            end
        end

        assign take_o  = take_q;
        assign cause_o = cause_q;

        // R8
        capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            take_o |-> (($past(pend_i) & $past(en_i)) >> cause_o) & NUM_IRQ'(1));

        // R8
        reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rst_n) |-> (!take_o && cause_o == '0));
    end else begin : g_comb
        assign take_o  = any_elig;
        assign cause_o = cause_d;
    end

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> cause_o == '0);

endmodule

// File: tb/irq_select_top_test.sv
// Bench: drives vectors on the falling edge and compares the registered
// outputs one clock later against a behavioural model.
module irq_select_top_test;

    localparam int N  = 32;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  pend, en, deleg;
    logic [1:0]    priv;
    logic          mg, sg;
    logic          take;
    logic [IW-1:0] cause;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    irq_select_top #(.NUM_IRQ(N), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .deleg_i(deleg),
        .priv_i(priv), .m_gie_i(mg), .s_gie_i(sg), .take_o(take), .cause_o(cause)
    );

    // Behavioural model: returns winning index or -1
    function automatic int model(input logic [N-1:0] p, input logic [N-1:0] e,
                                 input logic [N-1:0] d, input logic [1:0] pr,
                                 input logic m, input logic s);
        int  lvl;
        bit  mo, so;
        lvl = (pr == 2'd2) ? 0 : int'(pr);
        mo  = (lvl < 3) || m;
        so  = (lvl == 0) || (lvl == 1 && s);
        for (int i = 0; i < N; i++) begin
            if (p[i] && e[i] && ((d[i] && so) || (!d[i] && mo))) return i;
        end
        return -1;
    endfunction

    task automatic compare(input int exp, input string tag);
        logic          et;
        logic [IW-1:0] ec;
        et = (exp >= 0);
        ec = et ? exp[IW-1:0] : '0;
        checks++;
        if (take !== et || cause !== ec) begin
            errors++;
            $display("FAIL %s: take=%0b cause=%0d expected take=%0b cause=%0d",
                     tag, take, cause, et, ec);
        end
    endtask

    // Drive at a falling edge, check one clock later
    task automatic apply(input logic [N-1:0] p, input logic [N-1:0] e,
                         input logic [N-1:0] d, input logic [1:0] pr,
                         input logic m, input logic s, input string tag);
        int exp;
        pend = p; en = e; deleg = d; priv = pr; mg = m; sg = s;
        exp = model(p, e, d, pr, m, s);
        @(negedge clk);
        compare(exp, tag);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        pend = '1; en = '1; deleg = '0; priv = 2'd0; mg = 1'b1; sg = 1'b1;
        repeat (3) @(negedge clk);
        // R8: reset holds outputs clear even with eligible inputs
        compare(-1, "R8 reset");
        rst_n = 1'b1;

        // R1: pending without enable, then with enable
        apply(N'(1) << 3, '0, '0, 2'd0, 1'b0, 1'b0, "R1 enable clear");
        apply(N'(1) << 3, N'(1) << 3, '0, 2'd0, 1'b0, 1'b0, "R1 enabled");

        // R2: machine-routed source vs privilege and m_gie
        apply(N'(1) << 7, N'(1) << 7, '0, 2'd3, 1'b0, 1'b1, "R2 machine closed");
        apply(N'(1) << 7, N'(1) << 7, '0, 2'd3, 1'b1, 1'b0, "R2 machine open");
        apply(N'(1) << 7, N'(1) << 7, '0, 2'd1, 1'b0, 1'b0, "R2 below machine");

        // R3: supervisor-routed source
        apply(N'(1) << 5, N'(1) << 5, N'(1) << 5, 2'd3, 1'b1, 1'b1, "R3 at machine");
        apply(N'(1) << 5, N'(1) << 5, N'(1) << 5, 2'd1, 1'b1, 1'b0, "R3 super closed");
        apply(N'(1) << 5, N'(1) << 5, N'(1) << 5, 2'd1, 1'b0, 1'b1, "R3 super open");
        apply(N'(1) << 5, N'(1) << 5, N'(1) << 5, 2'd0, 1'b0, 1'b0, "R3 user");

        // R7: code 2 behaves as user
        apply(N'(1) << 9, N'(1) << 9, N'(1) << 9, 2'd2, 1'b0, 1'b0, "R7 code2 deleg");
        apply(N'(1) << 9, N'(1) << 9, '0, 2'd2, 1'b0, 1'b0, "R7 code2 mach");

        // R4: lower delegated source closed, higher machine source wins
        apply((N'(1) << 2) | (N'(1) << 11), (N'(1) << 2) | (N'(1) << 11),
              N'(1) << 2, 2'd3, 1'b1, 1'b1, "R4 skip closed low");
        apply((N'(1) << 2) | (N'(1) << 11), (N'(1) << 2) | (N'(1) << 11),
              N'(1) << 2, 2'd1, 1'b0, 1'b1, "R4 both open");

        // R5: extremes of priority
        apply((N'(1) << 31) | N'(1), '1, '0, 2'd0, 1'b0, 1'b0, "R5 bit0 beats bit31");
        apply(N'(1) << 31, '1, '1, 2'd0, 1'b0, 1'b0, "R5 top bit");

        // R6: nothing pending
        apply('0, '1, '0, 2'd3, 1'b1, 1'b1, "R6 idle");

        // R8: back-to-back changes track with one cycle of latency
        for (int k = 0; k < 300; k++) begin
            apply($urandom & $urandom, $urandom, $urandom, 2'($urandom),
                  1'($urandom), 1'($urandom), "R5 random");
        end

        // R8: reset mid-run clears outputs
        pend = '1; en = '1; deleg = '0; priv = 2'd0;
        rst_n = 1'b0;
        @(negedge clk);
        compare(-1, "R8 reset midrun");
        rst_n = 1'b1;
        apply('0, '0, '0, 2'd0, 1'b0, 1'b0, "R6 after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule